// File: doc/BRIEF.md
# Compressed Instruction Expander

The expander turns one 16-bit compressed instruction into the full-width 32-bit instruction word that has the same effect. It recognises six compressed forms: the signed halfword load with a register offset, the logical left and right shifts by an immediate amount, the logical left and right shifts by a register amount, and the load of an 8-bit immediate. Every word it produces carries the unconditional condition code. Any other 16-bit pattern raises an illegal flag and produces an all-zero word. The block does not execute instructions and does not access any register.

The translation itself is combinational. The parameter `REG_OUT` selects whether the result leaves through a registered output stage (1, the default) or goes straight to the ports (0). The registered stage is a three-state machine. `ST_EMPTY` is the state after reset, before any word has been captured. `ST_FRESH` means a word was captured on the last edge. `ST_HELD` means the stored word is kept but is no longer new. These are the transitions: from any state, a high `in_valid` moves to `ST_FRESH` and captures the word. From `ST_FRESH`, a low `in_valid` moves to `ST_HELD`. `ST_HELD` and `ST_EMPTY` stay where they are while `in_valid` is low. A synchronous reset returns the stage to `ST_EMPTY` and clears all outputs. `out_valid` is high only in `ST_FRESH`.

Top module: `cx_expander`

## Requirements
- R1: A half with bits [15:9]=0101111 (fields a=[8:6], b=[5:3], c=[2:0]) expands to 0xE19000F0 | b<<16 | c<<12 | a.
- R2: A half with bits [15:11]=00000 (amount n=[10:6], m=[5:3], d=[2:0]) expands to 0xE1B00000 | d<<12 | n<<7 | m, which is shift code 000 in bits [6:4].
- R3: A half with bits [15:11]=00001 (same fields as R2) expands to 0xE1B00020 | d<<12 | n<<7 | m, which is shift code 010 in bits [6:4].
- R4: A half with bits [15:6]=0100000010 or 0100000011 (s=[5:3], d=[2:0]) expands to 0xE1B00000 | d<<12 | s<<8 | d, ORed with 0x10 for the first pattern and with 0x30 for the second.
- R5: A half with bits [15:11]=00100 (d=[10:8], k=[7:0]) expands to 0xE3B00000 | d<<12 | k.
- R6: Every legal expanded word has bits [31:28]=1110, and each 3-bit register field appears zero-extended to 4 bits.
- R7: A half that matches none of the six forms sets out_illegal to 1 and makes out_word 0. A legal half sets out_illegal to 0.
- R8: With REG_OUT=1, a half presented with in_valid high appears on out_word and out_illegal one clock later, with out_valid high in that cycle.
- R9: With REG_OUT=1, a cycle with in_valid low leaves out_word and out_illegal unchanged, whatever is on in_half, and out_valid is low after it.
- R10: A synchronous reset drives out_word to 0, out_valid to 0 and out_illegal to 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | in_half is to be translated this cycle |
| in_half | input | 16 | Compressed instruction |
| out_valid | output | 1 | A freshly translated word is present |
| out_word | output | 32 | Expanded instruction, or 0 when illegal |
| out_illegal | output | 1 | in_half matched no known form |

## Verification
All 65536 values of `in_half` are swept in order with `in_valid` high. The sweep compares each of the six forms against a word that the bench assembles arithmetically from the extracted fields, and it checks that every remaining pattern gives zero and the illegal flag. The sweep covers the corners of the left and right immediate shift with amount 0, the zero-extension of register 7, and the neighbours of each opcode pattern, which must fall into the illegal class. Every 4096 values, a cycle with `in_valid` low and a different `in_half` is inserted. In that cycle the stored word must not move and `out_valid` must drop, which separates capture from hold. A reset applied in mid-run shows that the outputs clear.

// File: rtl/cx_pkg.sv
package cx_pkg;
    localparam int HALF_W = 16;
    localparam int WORD_W = 32;
    localparam int LO_W   = 3;
    localparam int REG_W  = 4;

    localparam logic [3:0] COND_ALWAYS = 4'b1110;

    typedef enum logic [2:0] {
        FORM_BAD,
        FORM_LDSH,
        FORM_SLI,
        FORM_SRI,
        FORM_SLR,
        FORM_SRR,
        FORM_MOVI
    } cx_form_e;

    typedef enum logic [1:0] {
        ST_EMPTY,
        ST_FRESH,
        ST_HELD
    } cx_stage_e;

    function automatic logic [REG_W-1:0] widen(input logic [LO_W-1:0] r);
        return {{(REG_W-LO_W){1'b0}}, r};
    endfunction
endpackage

// File: rtl/cx_decode.sv
module cx_decode
    import cx_pkg::*;
(
    input  logic [HALF_W-1:0] half,
    output cx_form_e          form
);
    always_comb begin
        form = FORM_BAD;
        if (half[15:9] == 7'b0101111)
            form = FORM_LDSH;
        else if (half[15:11] == 5'b00000)
            form = FORM_SLI;
        else if (half[15:11] == 5'b00001)
            form = FORM_SRI;
        else if (half[15:11] == 5'b00100)
            form = FORM_MOVI;
        else if (half[15:6] == 10'b0100000010)
            form = FORM_SLR;
        else if (half[15:6] == 10'b0100000011)
            form = FORM_SRR;
    end
endmodule

// File: rtl/cx_assemble.sv
module cx_assemble
    import cx_pkg::*;
(
    input  logic [HALF_W-1:0] half,
    input  cx_form_e          form,
    output logic [WORD_W-1:0] word,
    output logic              illegal
);
    logic [REG_W-1:0] f_lo, f_mid, f_hi, f_mv;

    assign f_lo  = widen(half[2:0]);
    assign f_mid = widen(half[5:3]);
    assign f_hi  = widen(half[8:6]);
    assign f_mv  = widen(half[10:8]);

    always_comb begin
        illegal = 1'b0;
        word    = '0;
        unique case (form)
            FORM_LDSH: word = {COND_ALWAYS, 8'b00011001, f_mid, f_lo,
                               4'b0000, 4'b1111, f_hi};
            FORM_SLI:  word = {COND_ALWAYS, 8'b00011011, 4'b0000, f_lo,
                               half[10:6], 3'b000, f_mid};
            FORM_SRI:  word = {COND_ALWAYS, 8'b00011011, 4'b0000, f_lo,
                               half[10:6], 3'b010, f_mid};
            FORM_SLR:  word = {COND_ALWAYS, 8'b00011011, 4'b0000, f_lo,
                               f_mid, 4'b0001, f_lo};
            FORM_SRR:  word = {COND_ALWAYS, 8'b00011011, 4'b0000, f_lo,
                               f_mid, 4'b0011, f_lo};
            FORM_MOVI: word = {COND_ALWAYS, 8'b00111011, 4'b0000, f_mv,
                               4'b0000, half[7:0]};
            default:   illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/cx_outstage.sv
module cx_outstage
    import cx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] d_word,
    input  logic              d_illegal,
    output logic              q_valid,
    output logic [WORD_W-1:0] q_word,
    output logic              q_illegal
);
    cx_stage_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: if (in_valid) state_nx = ST_FRESH;
            ST_FRESH: state_nx = in_valid ? ST_FRESH : ST_HELD;
            ST_HELD:  if (in_valid) state_nx = ST_FRESH;
            default:  state_nx = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_EMPTY;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_word    <= '0;
            q_illegal <= 1'b0;
        end else if (in_valid) begin
            q_word    <= d_word;
            q_illegal <= d_illegal;
        end
    end

    assign q_valid = (state == ST_FRESH);
endmodule

// File: rtl/cx_expander.sv
module cx_expander
    import cx_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [HALF_W-1:0] in_half,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic              out_illegal
);
    cx_form_e          form;
    logic [WORD_W-1:0] raw_word;
    logic              raw_illegal;

    cx_decode u_dec (.half(in_half), .form(form));
    cx_assemble u_asm (.half(in_half), .form(form), .word(raw_word), .illegal(raw_illegal));

    generate
        if (REG_OUT) begin : g_reg
            cx_outstage u_out (
                .clk(clk), .rst(rst), .in_valid(in_valid),
                .d_word(raw_word), .d_illegal(raw_illegal),
                .q_valid(out_valid), .q_word(out_word), .q_illegal(out_illegal)
            );
        end else begin : g_comb
            assign out_valid   = in_valid;
            assign out_word    = raw_word;
            assign out_illegal = raw_illegal;
        end
    endgenerate
endmodule

// File: rtl/cx_expander_chk.sv
module cx_expander_chk #(
    parameter bit REGISTERED = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        out_valid,
    input logic [31:0] out_word,
    input logic        out_illegal
);
    // R7: an illegal result carries an all-zero word
    a_r7_illegal_zero: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (out_word == 32'd0));

    // R6: a legal, valid word carries the unconditional code
    a_r6_cond_always: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_illegal) |-> (out_word[31:28] == 4'b1110));

    generate
        if (REGISTERED) begin : g_seq
            // R8: valid output follows an accepted input
            a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
                out_valid |-> $past(in_valid));

            // R9: idle cycle holds the word and drops valid
            a_r9_hold: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> ($stable(out_word) && $stable(out_illegal) && !out_valid));

            // R10: reset clears the outputs
            a_r10_reset_clear: assert property (@(posedge clk)
                rst |=> (out_word == 32'd0 && !out_valid && !out_illegal));
        end
    endgenerate
endmodule

bind cx_expander cx_expander_chk #(.REGISTERED(REG_OUT)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .out_valid(out_valid), .out_word(out_word), .out_illegal(out_illegal)
);

// File: tb/test_cx_expander.sv
`timescale 1ns/1ps
module test_cx_expander;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_half = 16'd0;
    logic        out_valid;
    logic [31:0] out_word;
    logic        out_illegal;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    cx_expander #(.REG_OUT(1'b1)) i_cx_expander (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_half(in_half),
        .out_valid(out_valid), .out_word(out_word), .out_illegal(out_illegal)
    );

    // Reference: builds the word from field values by arithmetic
    task automatic model(input logic [15:0] h, output logic [31:0] w,
                         output logic ill, output string req);
        int unsigned a, b, c, n, k;
        a = 32'(h[8:6]); b = 32'(h[5:3]); c = 32'(h[2:0]);
        n = 32'(h[10:6]); k = 32'(h[7:0]);
        ill = 1'b0; w = 32'd0;
        if ((h >> 9) == 16'h2F) begin
            req = "R1"; w = 32'hE19000F0 + (b << 16) + (c << 12) + a;
        end else if ((h >> 11) == 0) begin
            req = "R2"; w = 32'hE1B00000 + (c << 12) + (n << 7) + b;
        end else if ((h >> 11) == 1) begin
            req = "R3"; w = 32'hE1B00020 + (c << 12) + (n << 7) + b;
        end else if ((h >> 11) == 4) begin
            req = "R5"; w = 32'hE3B00000 + (32'(h[10:8]) << 12) + k;
        end else if ((h >> 6) == 16'h102) begin
            req = "R4"; w = 32'hE1B00010 + (c << 12) + (b << 8) + c;
        end else if ((h >> 6) == 16'h103) begin
            req = "R4"; w = 32'hE1B00030 + (c << 12) + (b << 8) + c;
        end else begin
            req = "R7"; ill = 1'b1;
        end
    endtask

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] w, last_w;
        logic        ill, last_ill;
        string       req;
        repeat (3) @(posedge clk);
        #1;
        check("R10", out_word, 32'd0, "reset word");
        check("R10", {31'd0, out_valid}, 32'd0, "reset valid");
        check("R10", {31'd0, out_illegal}, 32'd0, "reset illegal");
        @(negedge clk) rst = 1'b0;
        last_w = 32'd0; last_ill = 1'b0;

        for (int i = 0; i < 65536; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_half  = 16'(i);
            model(16'(i), w, ill, req);
            @(posedge clk);
            #1;
            check(req, out_word, w, $sformatf("word for half %h", i));
            check(ill ? "R7" : "R6", {31'd0, out_illegal}, {31'd0, ill},
                  $sformatf("illegal for half %h", i));
            check("R8", {31'd0, out_valid}, 32'd1, "valid after capture");
            last_w = w; last_ill = ill;
            if ((i % 4096) == 4095) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_half  = ~16'(i);
                @(posedge clk);
                #1;
                check("R9", out_word, last_w, "word held while idle");
                check("R9", {31'd0, out_illegal}, {31'd0, last_ill}, "illegal held while idle");
                check("R9", {31'd0, out_valid}, 32'd0, "valid low while idle");
            end
        end

        // Mid-run reset after a legal word
        @(negedge clk);
        in_valid = 1'b1;
        in_half  = 16'h20FF;
        @(posedge clk);
        #1;
        check("R5", out_word, 32'hE3B000FF, "move immediate before reset");
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R10", out_word, 32'd0, "word cleared by reset");
        check("R10", {31'd0, out_valid}, 32'd0, "valid cleared by reset");
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        @(posedge clk);
        #1;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule